// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the shared front end of a multi-channel event timer. It keeps the 64-bit free-running main counter, the global control word, a read-only capability word and the per-channel interrupt status. Software reaches all of it through a 32-bit-only memory-mapped port. Each 64-bit quantity is split into a low word at +0 and a high word at +4.

Every channel owns a 0x20-byte window starting at 0x100. The window holds the channel's configuration word, its 64-bit comparator and its 64-bit route word. The front end stores these values and hands them to the per-channel comparator logic, which lives outside this block. When the global enable changes, the block emits one-cycle arm or disarm strobes toward the channels. The channels report expirations back on a request vector, and those requests set the status bits. Software clears a status bit by writing a 1 to it.

The channel count is a parameter. It is clamped to the range 3 to 32, and the clamped value is reported in the capability word.

Top module: `etf_frontend`

## Requirements
- R1: After reset, the following values hold: counter 0, global control 0, status 0, every channel configuration 0, every comparator all ones, every route word 0, and no arm or disarm strobe.
- R2: Global control bit 0 is the enable. While it is 1, the main counter adds one on each clock where `tick_en` is high. While it is 0, the counter holds and reads return the held value. Counting resumes from the held value when the enable is set again.
- R3: The counter's low word is at 0x0F0 and its high word at 0x0F4. A write replaces only that half, whether the enable is 0 or 1, and takes precedence over an increment in the same cycle.
- R4: The capability low word at 0x000 reads as follows: [7:0]=1, [12:8]=channel count minus one, bit 13=1 (64-bit counter), bit 15=1 (legacy route capable), [31:16]=`VENDOR_ID`. The word at 0x004 reads `PERIOD_FS`. Writes to either word are ignored.
- R5: The global control word is at 0x010, with bit 0 as enable and bit 1 as legacy route (driven on `legacy_route`). Its other bits read 0. The word at 0x014 reads 0 and ignores writes.
- R6: Channel k has its window at 0x100+0x20*k. The window holds the configuration at +0x00 (only bits set in `CH_CFG_WMASK` are stored, the others read 0), a read-only `ROUTE_CAP` at +0x04, the comparator at +0x08/+0x0C and the route at +0x10/+0x14. All other offsets read 0.
- R7: An access to a channel window whose index is at or above the channel count reads 0 and changes nothing.
- R8: An access whose address bits [1:0] are not 0, and any unmapped global address, reads 0 and is ignored.
- R9: Status is at 0x020, where bit k is channel k. A `ch_irq_req[k]` pulse sets bit k while the enable is 1. Writing 1 clears a set bit, and writing 0 has no effect. A request in the same cycle as a clear of that bit leaves the bit set.
- R10: While the enable is 0, requests are ignored and status reads 0. A write that clears the enable clears all status bits and raises `ch_disarm` on every channel for the single following cycle.
- R11: A write that sets the enable raises `ch_arm[k]` for the single following cycle on each channel k whose comparator is not all ones.
- R12: A `NUM_CH` below 3 or above 32 is clamped to that range, and the clamped count sizes the ports and the capability field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick qualifier |
| bus_wr | input | 1 | Write strobe for the access port |
| bus_addr | input | ADDR_W | Byte address of the 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ch_irq_req | input | NCH | Expiration requests from the channels |
| glb_en | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy route select |
| main_count | output | 64 | Main counter value |
| ch_cfg | output | NCH*32 | Channel configuration words, channel k at [32k+:32] |
| ch_cmp | output | NCH*64 | Channel comparators, channel k at [64k+:64] |
| ch_route | output | NCH*64 | Channel route words, channel k at [64k+:64] |
| ch_arm | output | NCH | One-cycle arm strobe after the enable rises |
| ch_disarm | output | NCH | One-cycle disarm strobe after the enable falls |
| irq_status | output | NCH | Interrupt status bits |

## Verification
The checker watches several rules on every clock. It confirms that the counter steps by exactly one or holds depending on enable, tick and counter writes. It confirms that status stays empty while disabled and that written ones clear status bits. It also confirms that arm strobes last one cycle, occur only while enabled and never coincide with disarm, and that the upper control word and out-of-range channel windows read zero. Other behaviours only show up in the bench's scenarios: the exact capability encoding, stored-bit masking and readback across every channel window, carry into the high counter word, precedence of a counter write over a tick, and which channels receive an arm strobe. The same applies to the set-wins-over-clear ordering and to clamping of a too-small channel count.

// File: rtl/etf_pkg.sv
package etf_pkg;
   localparam int unsigned MIN_CH    = 3;
   localparam int unsigned MAX_CH    = 32;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned CNT_W     = 64;

   // global register byte offsets
   localparam int unsigned A_CAP_LO  = 'h000;
   localparam int unsigned A_CAP_HI  = 'h004;
   localparam int unsigned A_CFG_LO  = 'h010;
   localparam int unsigned A_CFG_HI  = 'h014;
   localparam int unsigned A_STS     = 'h020;
   localparam int unsigned A_CNT_LO  = 'h0F0;
   localparam int unsigned A_CNT_HI  = 'h0F4;

   // channel windows
   localparam int unsigned CH_BASE   = 'h100;
   localparam int unsigned CH_STRIDE = 'h20;
   localparam int unsigned CH_END    = CH_BASE + MAX_CH * CH_STRIDE;

   localparam logic [4:0] O_CFG_LO = 5'h00;
   localparam logic [4:0] O_CFG_HI = 5'h04;
   localparam logic [4:0] O_CMP_LO = 5'h08;
   localparam logic [4:0] O_CMP_HI = 5'h0C;
   localparam logic [4:0] O_RT_LO  = 5'h10;
   localparam logic [4:0] O_RT_HI  = 5'h14;

   function automatic int unsigned clamp_ch(input int unsigned n);
      if (n < MIN_CH) return MIN_CH;
      if (n > MAX_CH) return MAX_CH;
      return n;
   endfunction
endpackage

// File: rtl/etf_counter.sv
module etf_counter #(
   parameter int unsigned W  = 64,
   parameter int unsigned HW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [HW-1:0] wdata,
   output logic [W-1:0]  count
);
   if (W != 2 * HW) begin : g_bad_split
      $error("etf_counter: W must be twice HW");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_lo) begin
         count[HW-1:0] <= wdata;
      end else if (wr_hi) begin
         count[W-1:HW] <= wdata;
      end else if (run && tick) begin
         count <= count + W'(1);
      end
   end
endmodule

// File: rtl/etf_status.sv
module etf_status #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_req,
   input  logic         set_gate,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_mask,
   input  logic         clr_all,
   output logic [N-1:0] status
);
   logic [N-1:0] kept;
   logic [N-1:0] added;

   always_comb begin
      kept  = clr_wr ? (status & ~clr_mask) : status;
      added = set_gate ? set_req : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       status <= '0;
      else if (clr_all) status <= '0;
      else              status <= kept | added;
   end
endmodule

// File: rtl/etf_chan_regs.sv
module etf_chan_regs
   import etf_pkg::*;
#(
   parameter logic [31:0] CFG_WMASK = 32'h0000_00FF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [4:0]  reg_off,
   input  logic [31:0] wdata,
   output logic [31:0] cfg,
   output logic [63:0] cmp,
   output logic [63:0] route
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg   <= '0;
         cmp   <= '1;
         route <= '0;
      end else if (wr_en) begin
         case (reg_off)
            O_CFG_LO: cfg          <= wdata & CFG_WMASK;
            O_CMP_LO: cmp[31:0]    <= wdata;
            O_CMP_HI: cmp[63:32]   <= wdata;
            O_RT_LO:  route[31:0]  <= wdata;
            O_RT_HI:  route[63:32] <= wdata;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/etf_frontend.sv
module etf_frontend
   import etf_pkg::*;
#(
   parameter int unsigned NUM_CH       = 3,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [15:0] VENDOR_ID    = 16'h0000,
   parameter logic [31:0] PERIOD_FS    = 32'd10000000,
   parameter logic [31:0] ROUTE_CAP    = 32'h00F0_0000,
   parameter logic [31:0] CH_CFG_WMASK = 32'h0000_00FF,
   localparam int unsigned NCH         = clamp_ch(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NCH-1:0]    ch_irq_req,
   output logic              glb_en,
   output logic              legacy_route,
   output logic [63:0]       main_count,
   output logic [NCH*32-1:0] ch_cfg,
   output logic [NCH*64-1:0] ch_cmp,
   output logic [NCH*64-1:0] ch_route,
   output logic [NCH-1:0]    ch_arm,
   output logic [NCH-1:0]    ch_disarm,
   output logic [NCH-1:0]    irq_status
);
   localparam int unsigned IDX_W = ADDR_W - 5;
   localparam logic [31:0] CAP_LO =
      {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};

   if (ADDR_W < 11) begin : g_bad_aw
      $error("etf_frontend: ADDR_W must cover the channel area");
   end
   if (PERIOD_FS == 32'd0) begin : g_bad_period
      $error("etf_frontend: PERIOD_FS must be nonzero");
   end

   // ---------------- address decode ----------------
   logic              aligned;
   logic              in_ch_area;
   logic [ADDR_W-1:0] ch_off;
   logic [IDX_W-1:0]  ch_idx;
   logic [4:0]        ch_reg;
   logic              ch_hit;

   assign aligned    = (bus_addr[1:0] == 2'b00);
   assign in_ch_area = (bus_addr >= ADDR_W'(CH_BASE)) && (bus_addr < ADDR_W'(CH_END));
   assign ch_off     = bus_addr - ADDR_W'(CH_BASE);
   assign ch_idx     = ch_off[ADDR_W-1:5];
   assign ch_reg     = ch_off[4:0];
   assign ch_hit     = aligned && in_ch_area && (ch_idx < IDX_W'(NCH));

   logic wr_cfg, wr_sts, wr_cnt_lo, wr_cnt_hi;
   assign wr_cfg    = bus_wr && (bus_addr == ADDR_W'(A_CFG_LO));
   assign wr_sts    = bus_wr && (bus_addr == ADDR_W'(A_STS));
   assign wr_cnt_lo = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO));
   assign wr_cnt_hi = bus_wr && (bus_addr == ADDR_W'(A_CNT_HI));

   // ---------------- global control ----------------
   logic en_d;
   logic en_falling;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_en       <= 1'b0;
         legacy_route <= 1'b0;
         en_d         <= 1'b0;
      end else begin
         en_d <= glb_en;
         if (wr_cfg) begin
            glb_en       <= bus_wdata[0];
            legacy_route <= bus_wdata[1];
         end
      end
   end

   assign en_falling = wr_cfg && glb_en && !bus_wdata[0];

   // ---------------- counter and status ----------------
   etf_counter #(.W(CNT_W), .HW(WORD_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (glb_en),
      .tick  (tick_en),
      .wr_lo (wr_cnt_lo),
      .wr_hi (wr_cnt_hi),
      .wdata (bus_wdata),
      .count (main_count)
   );

   etf_status #(.N(NCH)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (ch_irq_req),
      .set_gate (glb_en),
      .clr_wr   (wr_sts),
      .clr_mask (bus_wdata[NCH-1:0]),
      .clr_all  (en_falling),
      .status   (irq_status)
   );

   // ---------------- channel windows ----------------
   logic [31:0]    cfg_a [NCH];
   logic [63:0]    cmp_a [NCH];
   logic [63:0]    rt_a  [NCH];
   logic [NCH-1:0] cmp_ones;

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic sel;
      assign sel = bus_wr && ch_hit && (ch_idx == IDX_W'(k));

      etf_chan_regs #(.CFG_WMASK(CH_CFG_WMASK)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (sel),
         .reg_off (ch_reg),
         .wdata   (bus_wdata),
         .cfg     (cfg_a[k]),
         .cmp     (cmp_a[k]),
         .route   (rt_a[k])
      );

      assign ch_cfg[k*32 +: 32]   = cfg_a[k];
      assign ch_cmp[k*64 +: 64]   = cmp_a[k];
      assign ch_route[k*64 +: 64] = rt_a[k];
      assign cmp_ones[k]          = &cmp_a[k];
   end

   assign ch_arm    = (glb_en && !en_d) ? ~cmp_ones : '0;
   assign ch_disarm = (!glb_en && en_d) ? '1 : '0;

   // ---------------- read mux ----------------
   logic [31:0] sel_cfg;
   logic [63:0] sel_cmp;
   logic [63:0] sel_rt;

   always_comb begin
      sel_cfg = '0;
      sel_cmp = '0;
      sel_rt  = '0;
      for (int k = 0; k < NCH; k++) begin
         if (ch_idx == IDX_W'(k)) begin
            sel_cfg = cfg_a[k];
            sel_cmp = cmp_a[k];
            sel_rt  = rt_a[k];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ch_hit) begin
         case (ch_reg)
            O_CFG_LO: bus_rdata = sel_cfg;
            O_CFG_HI: bus_rdata = ROUTE_CAP;
            O_CMP_LO: bus_rdata = sel_cmp[31:0];
            O_CMP_HI: bus_rdata = sel_cmp[63:32];
            O_RT_LO:  bus_rdata = sel_rt[31:0];
            O_RT_HI:  bus_rdata = sel_rt[63:32];
            default:  bus_rdata = '0;
         endcase
      end else if (aligned && !in_ch_area) begin
         case (bus_addr)
            ADDR_W'(A_CAP_LO): bus_rdata = CAP_LO;
            ADDR_W'(A_CAP_HI): bus_rdata = PERIOD_FS;
            ADDR_W'(A_CFG_LO): bus_rdata = {30'b0, legacy_route, glb_en};
            ADDR_W'(A_STS):    bus_rdata = 32'(irq_status);
            ADDR_W'(A_CNT_LO): bus_rdata = main_count[31:0];
            ADDR_W'(A_CNT_HI): bus_rdata = main_count[63:32];
            default:           bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/etf_frontend_chk.sv
module etf_frontend_chk
   import etf_pkg::*;
#(
   parameter int unsigned NCH    = 3,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NCH-1:0]    sts_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NCH-1:0]    ch_irq_req,
   input logic              glb_en,
   input logic [63:0]       main_count,
   input logic [NCH-1:0]    ch_arm,
   input logic [NCH-1:0]    ch_disarm,
   input logic [NCH-1:0]    irq_status
);
   logic              cnt_wr;
   logic [ADDR_W-1:0] off;
   logic              oor_ch;

   assign cnt_wr = bus_wr && ((bus_addr == ADDR_W'(A_CNT_LO)) || (bus_addr == ADDR_W'(A_CNT_HI)));
   assign off    = bus_addr - ADDR_W'(CH_BASE);
   assign oor_ch = (bus_addr >= ADDR_W'(CH_BASE)) && (bus_addr < ADDR_W'(CH_END))
                   && ((off >> 5) >= ADDR_W'(NCH));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !cnt_wr) |=> (main_count == $past(main_count)));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && tick_en && !cnt_wr) |=> (main_count == $past(main_count) + 64'd1));

   assert_cfg_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(A_CFG_HI)) |-> (bus_rdata == 32'd0));

   assert_oor_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oor_ch |-> (bus_rdata == 32'd0));

   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == ADDR_W'(A_STS)) && (ch_irq_req == '0))
      |=> ((irq_status & $past(sts_wdata)) == '0));

   assert_idle_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> (irq_status == '0));

   assert_arm_disarm_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !((|ch_arm) && (|ch_disarm)));

   assert_arm_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_arm) |-> glb_en);

   assert_arm_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_arm) |=> (ch_arm == '0));
endmodule

bind etf_frontend etf_frontend_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .sts_wdata  (bus_wdata[NCH-1:0]),
   .bus_rdata  (bus_rdata),
   .ch_irq_req (ch_irq_req),
   .glb_en     (glb_en),
   .main_count (main_count),
   .ch_arm     (ch_arm),
   .ch_disarm  (ch_disarm),
   .irq_status (irq_status)
);

// File: tb/etf_frontend_tb.sv
module etf_frontend_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          NCH  = 3;
   localparam int          AW   = 12;
   localparam logic [15:0] VID  = 16'h5A3C;
   localparam logic [31:0] PFS  = 32'd69841279;
   localparam logic [31:0] RCAP = 32'h00C0_0F00;
   localparam logic [31:0] WM   = 32'h0000_00FF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b0;
   logic              bus_wr = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    ch_irq_req = '0;
   logic              glb_en, legacy_route;
   logic [63:0]       main_count;
   logic [NCH*32-1:0] ch_cfg;
   logic [NCH*64-1:0] ch_cmp, ch_route;
   logic [NCH-1:0]    ch_arm, ch_disarm, irq_status;

   logic [31:0]       c_rdata;
   logic              c_en, c_leg;
   logic [63:0]       c_cnt;
   logic [3*32-1:0]   c_cfg;
   logic [3*64-1:0]   c_cmp, c_rt;
   logic [2:0]        c_arm, c_dis, c_sts;

   always #(CLK_PERIOD / 2) clk = ~clk;

   etf_frontend #(
      .NUM_CH(NCH), .ADDR_W(AW), .VENDOR_ID(VID), .PERIOD_FS(PFS),
      .ROUTE_CAP(RCAP), .CH_CFG_WMASK(WM)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_irq_req(ch_irq_req), .glb_en(glb_en), .legacy_route(legacy_route),
      .main_count(main_count), .ch_cfg(ch_cfg), .ch_cmp(ch_cmp),
      .ch_route(ch_route), .ch_arm(ch_arm), .ch_disarm(ch_disarm),
      .irq_status(irq_status)
   );

   // second instance with a too-small channel count (R12)
   etf_frontend #(.NUM_CH(1), .ADDR_W(AW)) u_clamp (
      .clk(clk), .rst_n(rst_n), .tick_en(1'b0), .bus_wr(1'b0),
      .bus_addr('0), .bus_wdata('0), .bus_rdata(c_rdata),
      .ch_irq_req(3'b000), .glb_en(c_en), .legacy_route(c_leg),
      .main_count(c_cnt), .ch_cfg(c_cfg), .ch_cmp(c_cmp), .ch_route(c_rt),
      .ch_arm(c_arm), .ch_disarm(c_dis), .irq_status(c_sts)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wr   = 1'b0;
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, 64'(v), 64'(exp));
   endtask

   function automatic logic [31:0] pat(input int k, input int o);
      return 32'hC0DE_0000 ^ 32'(k << 8) ^ 32'(o);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      logic [31:0] cap_exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      #1;
      check("R1 glb_en", 64'(glb_en), 64'd0);
      check("R1 arm/disarm", 64'({ch_arm, ch_disarm}), 64'd0);
      rd_check("R1 count lo", 12'h0F0, 32'd0);
      rd_check("R1 count hi", 12'h0F4, 32'd0);
      rd_check("R1 cfg", 12'h010, 32'd0);
      rd_check("R1 status", 12'h020, 32'd0);
      for (int k = 0; k < NCH; k++) begin
         rd_check("R1 ch cfg", 12'(256 + 32 * k), 32'd0);
         rd_check("R1 ch cmp lo", 12'(256 + 32 * k + 8), 32'hFFFF_FFFF);
         rd_check("R1 ch cmp hi", 12'(256 + 32 * k + 12), 32'hFFFF_FFFF);
         rd_check("R1 ch route", 12'(256 + 32 * k + 16), 32'd0);
      end

      // R4 capability, R12 clamp
      cap_exp = {VID, 3'b101, 5'(NCH - 1), 8'h01};
      rd_check("R4 cap lo", 12'h000, cap_exp);
      rd_check("R4 cap hi", 12'h004, PFS);
      wr(12'h000, 32'd0);
      wr(12'h004, 32'd0);
      rd_check("R4 cap lo after write", 12'h000, cap_exp);
      rd_check("R4 cap hi after write", 12'h004, PFS);
      check("R12 clamped count field", 64'(c_rdata[12:8]), 64'd2);

      // R5 global control
      wr(12'h010, 32'hFFFF_FFFC);
      rd_check("R5 cfg other bits", 12'h010, 32'd0);
      wr(12'h014, 32'hFFFF_FFFF);
      rd_check("R5 cfg hi", 12'h014, 32'd0);
      wr(12'h010, 32'h0000_0002);
      rd_check("R5 legacy bit", 12'h010, 32'd2);
      check("R5 legacy pin", 64'(legacy_route), 64'd1);
      wr(12'h010, 32'd0);

      // R6 sweep of every implemented channel window
      for (int k = 0; k < NCH; k++) begin
         wr(12'(256 + 32 * k), 32'hA5A5_5A5A ^ 32'(k));
         wr(12'(256 + 32 * k + 4), 32'hFFFF_FFFF);
         for (int o = 8; o <= 20; o += 4) wr(12'(256 + 32 * k + o), pat(k, o));
      end
      for (int k = 0; k < NCH; k++) begin
         rd_check("R6 ch cfg mask", 12'(256 + 32 * k), (32'hA5A5_5A5A ^ 32'(k)) & WM);
         rd_check("R6 ch cap", 12'(256 + 32 * k + 4), RCAP);
         for (int o = 8; o <= 20; o += 4)
            rd_check("R6 ch readback", 12'(256 + 32 * k + o), pat(k, o));
         rd_check("R6 offset 0x18", 12'(256 + 32 * k + 24), 32'd0);
         rd_check("R6 offset 0x1C", 12'(256 + 32 * k + 28), 32'd0);
      end
      check("R6 cmp port ch2", ch_cmp[2*64 +: 64], {pat(2, 12), pat(2, 8)});

      // R7 channel beyond the count
      wr(12'h168, 32'h1234_5678);
      rd_check("R7 oor read", 12'h168, 32'd0);
      rd_check("R7 oor far", 12'h488, 32'd0);
      rd_check("R7 ch0 untouched", 12'h108, pat(0, 8));

      // R8 unaligned and unmapped
      wr(12'h011, 32'd1);
      rd_check("R8 unaligned write ignored", 12'h010, 32'd0);
      rd_check("R8 unaligned read", 12'h012, 32'd0);
      rd_check("R8 unmapped read", 12'h030, 32'd0);

      // R11 arm strobe: channel 1 comparator back to all ones
      wr(12'h128, 32'hFFFF_FFFF);
      wr(12'h12C, 32'hFFFF_FFFF);
      wr(12'h010, 32'd1);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 check("R11 arm after enable", 64'(ch_arm), 64'b101);
      @(negedge clk);
      #1 check("R11 arm one cycle", 64'(ch_arm), 64'd0);

      // R10 disarm on falling enable
      wr(12'h010, 32'd0);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 check("R10 disarm all", 64'(ch_disarm), 64'b111);

      // R2 counting with carry
      wr(12'h0F0, 32'hFFFF_FFFE);
      wr(12'h0F4, 32'd0);
      wr(12'h010, 32'd1);
      @(negedge clk);
      bus_wr  = 1'b0;
      tick_en = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
      rd_check("R2 count lo", 12'h0F0, 32'd3);
      rd_check("R2 count hi carry", 12'h0F4, 32'd1);
      wr(12'h010, 32'd0);
      @(negedge clk);
      bus_wr  = 1'b0;
      tick_en = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
      rd_check("R2 hold while disabled", 12'h0F0, 32'd3);

      // R3 write while enabled wins over tick
      wr(12'h010, 32'd1);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = 12'h0F0;
      bus_wdata = 32'h55;
      tick_en   = 1'b1;
      @(negedge clk);
      bus_wr  = 1'b0;
      tick_en = 1'b0;
      #1 check("R3 write beats tick", 64'(bus_rdata), 64'h55);
      wr(12'h0F4, 32'hABCD);
      rd_check("R3 hi write enabled", 12'h0F4, 32'hABCD);
      rd_check("R3 lo kept", 12'h0F0, 32'h55);

      // R9 status
      @(negedge clk);
      ch_irq_req = 3'b011;
      @(negedge clk);
      ch_irq_req = 3'b000;
      rd_check("R9 set", 12'h020, 32'd3);
      wr(12'h020, 32'd6);
      rd_check("R9 w1c only set bits", 12'h020, 32'd1);
      wr(12'h020, 32'd0);
      rd_check("R9 zeros no effect", 12'h020, 32'd1);
      @(negedge clk);
      bus_wr     = 1'b1;
      bus_addr   = 12'h020;
      bus_wdata  = 32'd1;
      ch_irq_req = 3'b001;
      @(negedge clk);
      ch_irq_req = 3'b000;
      bus_wr     = 1'b0;
      rd_check("R9 set wins over clear", 12'h020, 32'd1);
      wr(12'h020, 32'd1);
      rd_check("R9 clear bit0", 12'h020, 32'd0);

      // R10 disable clears status, requests ignored
      @(negedge clk);
      ch_irq_req = 3'b100;
      @(negedge clk);
      ch_irq_req = 3'b000;
      rd_check("R10 set before disable", 12'h020, 32'd4);
      wr(12'h010, 32'd0);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 check("R10 disarm strobe", 64'(ch_disarm), 64'b111);
      check("R10 status cleared", 64'(irq_status), 64'd0);
      @(negedge clk);
      ch_irq_req = 3'b111;
      @(negedge clk);
      ch_irq_req = 3'b000;
      rd_check("R10 requests ignored", 12'h020, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule